// File: doc/BRIEF.md
# HDLC Transmit Byte Queue with Frame Length and Sent-Byte Counter

This block sits between a host register port and a serial HDLC transmitter. For each host write it stores one 10-bit word: the data byte plus two frame-control tags, end-of-packet and abort. The tags are sampled from control inputs at the moment of the write. The transmitter asks for bytes with a one-cycle request. The block then takes the oldest word and shifts its data out one bit per cycle, least significant bit first.

Alongside the queue, the host programs a frame-length register. It holds the size of the payload of the frame about to be sent, not counting address, flags or check sequence. A running counter reports how many payload bytes of the current frame have left the queue. The empty and full flags lag the true occupancy by two clock edges. A popped word tagged abort raises a one-cycle abort indication and throws away the rest of that frame. A write into a full queue is lost and latches a sticky overflow flag.

Flag generation, zero insertion and check-sequence computation belong to the transmitter. They are not part of this block.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: Each cycle with `wr_en` high stores the word {ctl_abort (bit 9), ctl_eop (bit 8), wr_data (bits 7:0)} when the queue is not full. Words leave in write order.
- R2: A pop of a word whose abort tag is 0 starts serialisation. `ser_valid` is high for exactly the 8 cycles after the pop edge. `ser_bit` carries data bit 0 first and bit 7 last. `ser_eop` equals the word's end-of-packet tag while `ser_valid` is high.
- R3: `fifo_empty` and `fifo_full` show the occupancy as it stood two clock edges earlier. After a write into an empty queue at edge T, `fifo_empty` stays 1 after edges T and T+1 and first reads 0 after edge T+2.
- R4: `frame_len` loads `len_data` on a cycle with `len_wr` high. It keeps its value otherwise, and resets to 0.
- R5: `sent_cnt` rises by one for each payload word popped. It becomes 0 when the popped word carries the end-of-packet tag.
- R6: When the popped word has its abort tag set, `tx_abort` is high for exactly one cycle after the pop and `sent_cnt` becomes 0. No data is serialised for that word. If the word lacks end-of-packet, the following words, up to and including the next end-of-packet word, are removed without being serialised or counted.
- R7: A write while the queue holds DEPTH words is dropped, even if a pop occurs in the same cycle. The write sets `overflow`, which stays 1 until reset.
- R8: `byte_req` is ignored while a byte is being shifted out, while frame words are being discarded, and while the queue is empty.
- R9: After reset, `fifo_empty` is 1 and the following are all 0: `fifo_full`, `overflow`, `sent_cnt`, `frame_len`, `ser_valid` and `tx_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for one data byte |
| wr_data | input | 8 | Data byte to queue |
| ctl_eop | input | 1 | End-of-packet tag sampled with the write |
| ctl_abort | input | 1 | Abort tag sampled with the write |
| len_wr | input | 1 | Load strobe for the frame-length register |
| len_data | input | CNT_W | New frame length (payload bytes) |
| frame_len | output | CNT_W | Programmed payload length |
| sent_cnt | output | CNT_W | Payload bytes of the current frame taken from the queue |
| fifo_empty | output | 1 | Delayed empty flag |
| fifo_full | output | 1 | Delayed full flag |
| overflow | output | 1 | Sticky flag: a write was lost while full |
| byte_req | input | 1 | Transmitter request for the next byte |
| ser_valid | output | 1 | Serial bit valid |
| ser_bit | output | 1 | Serial data, LSB first |
| ser_eop | output | 1 | The byte being shifted ends the frame |
| tx_abort | output | 1 | One-cycle frame-abort indication |

## Verification
The bench targets bit order. A design that shifted MSB first would emit a byte such as 0xA5 reversed. It checks the two-edge lag of the empty flag, which a design with combinational flags would clear one or two cycles early. The abort case checks that the words after the abort are discarded through the end-of-packet word and that the next frame still goes out. A design that discarded too little would serialise stale bytes, and one that discarded too much would swallow the following frame. A ninth write into the eight-deep queue must leave the first eight words intact and latch overflow. A holding `byte_req` during shifting must not advance `sent_cnt`.

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             ctl_eop,
  input  logic             ctl_abort,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_data,
  output logic [CNT_W-1:0] frame_len,
  output logic [CNT_W-1:0] sent_cnt,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             overflow,
  input  logic             byte_req,
  output logic             ser_valid,
  output logic             ser_bit,
  output logic             ser_eop,
  output logic             tx_abort
);
  // DEPTH must be a power of two; pointers wrap naturally.
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level, lvl_d1, lvl_d2;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic          busy, eop_r, discard;

  wire       push = wr_en && (level != FULL_LVL);
  wire       pop  = (level != '0) && (discard || (byte_req && !busy));
  wire [9:0] head = mem[rd_ptr];

  assign fifo_empty = (lvl_d2 == '0);
  assign fifo_full  = (lvl_d2 == FULL_LVL);
  assign ser_valid  = busy;
  assign ser_bit    = shreg[0];
  assign ser_eop    = busy && eop_r;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {ctl_abort, ctl_eop, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; level <= '0;
      lvl_d1 <= '0; lvl_d2 <= '0; overflow <= 1'b0;
      frame_len <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      level  <= level + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      lvl_d1 <= level;
      lvl_d2 <= lvl_d1;
      if (wr_en && !push) overflow <= 1'b1;
      if (len_wr) frame_len <= len_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; bitn <= '0; shreg <= '0; eop_r <= 1'b0;
      discard <= 1'b0; tx_abort <= 1'b0; sent_cnt <= '0;
    end else begin
      tx_abort <= 1'b0;
      if (busy) begin
        shreg <= shreg >> 1;
        bitn  <= bitn + 3'd1;
        if (bitn == 3'd7) busy <= 1'b0;
      end else if (pop) begin
        if (discard) begin
          if (head[8]) discard <= 1'b0;
        end else if (head[9]) begin
          tx_abort <= 1'b1;
          sent_cnt <= '0;
          discard  <= !head[8];
        end else begin
          shreg    <= head[7:0];
          eop_r    <= head[8];
          busy     <= 1'b1;
          bitn     <= '0;
          sent_cnt <= head[8] ? '0 : sent_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

module hdlc_tx_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             len_wr,
  input logic [CNT_W-1:0] frame_len,
  input logic [CNT_W-1:0] sent_cnt,
  input logic             overflow,
  input logic             ser_valid,
  input logic             tx_abort,
  input logic [$clog2(DEPTH):0] level
);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r7_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && level == ($clog2(DEPTH)+1)'(DEPTH)) |=> overflow);
  a_r6_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort);
  a_r6_abort_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> sent_cnt == '0);
  a_r8_no_pop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |=> $stable(sent_cnt));
  a_r4_len_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !len_wr |=> $stable(frame_len));
  a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sent_cnt) |-> (sent_cnt == '0 || sent_cnt == $past(sent_cnt) + CNT_W'(1)));
endmodule

bind hdlc_tx_fifo hdlc_tx_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .len_wr(len_wr),
  .frame_len(frame_len), .sent_cnt(sent_cnt), .overflow(overflow),
  .ser_valid(ser_valid), .tx_abort(tx_abort), .level(level));

// File: tb/tb_hdlc_tx_fifo.sv
module tb_hdlc_tx_fifo;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, ctl_eop = 0, ctl_abort = 0, len_wr = 0, byte_req = 0;
  logic [7:0] wr_data = 0;
  logic [CNT_W-1:0] len_data = 0, frame_len, sent_cnt;
  logic fifo_empty, fifo_full, overflow, ser_valid, ser_bit, ser_eop, tx_abort;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (.*);

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic e, logic a);
    @(negedge clk);
    wr_en = 1; wr_data = d; ctl_eop = e; ctl_abort = a;
    @(negedge clk);
    wr_en = 0; ctl_eop = 0; ctl_abort = 0;
  endtask

  // Pulse byte_req, then collect 8 serial bits starting the cycle after the pop.
  task automatic get_byte(output logic [7:0] d, output logic e);
    d = 'x; e = 0;
    @(negedge clk); byte_req = 1;
    @(negedge clk); byte_req = 0;
    check("R2 ser_valid after pop", ser_valid, 1);
    e = ser_eop;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      d[i] = ser_bit;
    end
    @(negedge clk);
    check("R2 ser_valid ends after 8 bits", ser_valid, 0);
  endtask

  task automatic t_reset;
    check("R9 empty", fifo_empty, 1);
    check("R9 full", fifo_full, 0);
    check("R9 overflow", overflow, 0);
    check("R9 sent_cnt", sent_cnt, 0);
    check("R9 frame_len", frame_len, 0);
    check("R9 ser_valid", ser_valid, 0);
    check("R9 tx_abort", tx_abort, 0);
  endtask

  task automatic t_len;
    @(negedge clk); len_wr = 1; len_data = 8'd37;
    @(negedge clk); len_wr = 0; len_data = 8'd99;
    check("R4 load", frame_len, 37);
    repeat (3) @(negedge clk);
    check("R4 hold", frame_len, 37);
  endtask

  task automatic t_flag_delay;
    logic [7:0] d; logic e;
    push(8'h6E, 1, 0);
    check("R3 empty after T", fifo_empty, 1);
    @(negedge clk);
    check("R3 empty after T+1", fifo_empty, 1);
    @(negedge clk);
    check("R3 empty clears after T+2", fifo_empty, 0);
    get_byte(d, e);
    check("R1 data", d, 8'h6E);
    check("R2 eop tag", e, 1);
    check("R5 eop clears count", sent_cnt, 0);
    repeat (2) @(negedge clk);
    check("R3 empty again", fifo_empty, 1);
  endtask

  task automatic t_serial;
    logic [7:0] d; logic e;
    push(8'hA5, 0, 0);
    push(8'h3C, 0, 0);
    push(8'h81, 1, 0);
    get_byte(d, e);
    check("R2 LSB first A5", d, 8'hA5);
    check("R2 eop low", e, 0);
    check("R5 count 1", sent_cnt, 1);
    get_byte(d, e);
    check("R1 order 3C", d, 8'h3C);
    check("R5 count 2", sent_cnt, 2);
    get_byte(d, e);
    check("R2 LSB first 81", d, 8'h81);
    check("R2 eop high", e, 1);
    check("R5 count cleared", sent_cnt, 0);
  endtask

  task automatic t_busy;
    logic [7:0] d; logic e;
    push(8'h10, 0, 0);
    push(8'h20, 1, 0);
    @(negedge clk); byte_req = 1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      check("R8 no pop while shifting", sent_cnt, 1);
    end
    @(negedge clk); byte_req = 0;
    check("R8 second pop after byte", sent_cnt, 0);
    repeat (9) @(negedge clk);
    @(negedge clk); byte_req = 1;
    @(negedge clk); byte_req = 0;
    check("R8 request on empty ignored", ser_valid, 0);
    d = 0; e = 0;
  endtask

  task automatic t_abort;
    logic [7:0] d; logic e;
    push(8'h11, 0, 0);
    push(8'h22, 0, 1);
    push(8'h33, 0, 0);
    push(8'h44, 1, 0);
    push(8'h55, 1, 0);
    get_byte(d, e);
    check("R1 pre-abort byte", d, 8'h11);
    check("R5 count before abort", sent_cnt, 1);
    @(negedge clk); byte_req = 1;
    @(negedge clk); byte_req = 0;
    check("R6 abort pulse", tx_abort, 1);
    check("R6 no serial for abort word", ser_valid, 0);
    check("R6 count cleared", sent_cnt, 0);
    @(negedge clk);
    check("R6 abort one cycle", tx_abort, 0);
    repeat (5) @(negedge clk);
    check("R6 discarded words not serialised", ser_valid, 0);
    get_byte(d, e);
    check("R6 next frame survives", d, 8'h55);
    check("R6 next frame eop", e, 1);
  endtask

  task automatic t_overflow;
    logic [7:0] d; logic e;
    for (int i = 0; i < DEPTH + 1; i++) push(8'h80 + 8'(i), i == DEPTH - 1, 0);
    check("R7 overflow set", overflow, 1);
    @(negedge clk);
    check("R3 full after two edges", fifo_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      get_byte(d, e);
      check("R7 stored words intact", d, 8'h80 + i);
    end
    repeat (3) @(negedge clk);
    check("R7 dropped word absent", fifo_empty, 1);
    check("R7 overflow sticky", overflow, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_len;
    t_flag_delay;
    t_serial;
    t_busy;
    t_abort;
    t_overflow;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule